// File: doc/BRIEF.md
# Bridge Read Prefetch Policy Controller

This block sits in the read path of a bus bridge and decides how far an incoming read is fetched on the far side. When a read is accepted, the block looks at its command, its DWORD address within the 4 KB page, its byte enables, whether the address hit prefetchable space, the bus mode, a DWORD-read flag, the buffering control fields, the cache line size and the free space in the prefetch buffer. From these it picks one of three policies: a single non-speculative DWORD, a fetch up to the next cache line boundary, or a buffer fill.

The chosen policy yields a DWORD count, the byte enables to drive on each outbound data phase, and a flag telling the initiator side to disconnect after one DWORD. A tracker then counts the data phases down and reports the final one, so the fetch stops exactly at the computed limit. Bus signalling, data storage and configuration access live elsewhere.

Top module: `rd_prefetch_ctl`

## Requirements
- R1: The command field codes are 0 I/O read, 1 configuration read, 2 memory read, 3 memory read line, 4 memory read multiple; codes 0, 1, 5, 6, 7 and a memory read (code 2) with `pf_hit` low are non-speculative: count 1, `disc_one` high, `phase_be` equal to the captured `be_in`.
- R2: With `pcix_mode` high and `dword_rd` high, any command is non-speculative as in R1.
- R3: Every speculative read drives `phase_be` = 4'b1111 on all its data phases and leaves `disc_one` low.
- R4: A memory read with `pf_hit` high follows `mr_ctl`: 2'b00 is non-speculative (R1 outputs), 2'b01 fetches to the cache line boundary, 2'b10 and 2'b11 fill the buffer.
- R5: Memory read line and memory read multiple are always speculative; `mrlm_ctl` 0 fetches to the line boundary, 1 fills the buffer.
- R6: The line length is 2^`line_log2` DWORDs; a line fetch is that length minus the offset of `dw_addr` within the line.
- R7: A speculative count is the minimum of the policy length, the free space (`free_dw` clamped to the buffer size) and the DWORDs left before the 4 KB page end, and is never below 1.
- R8: An accepted request sets `busy` and `remain` to the count on the next edge; each `phase_adv` while busy lowers `remain` by one, `last_phase` is high while exactly one phase is left, and `busy` drops after the final phase.
- R9: `req_valid` while busy, and `phase_adv` while idle, change no output.
- R10: After reset `busy`, `fetch_cnt`, `remain`, `phase_be`, `disc_one` and `last_phase` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered; accepted when idle |
| cmd | input | 3 | Read command code (R1) |
| dw_addr | input | PG_W (10) | DWORD address within the 4 KB page |
| be_in | input | 4 | Byte enables of the original request |
| pf_hit | input | 1 | Address lies in prefetchable space |
| pcix_mode | input | 1 | Bridge side runs in PCI-X mode |
| dword_rd | input | 1 | Request is a DWORD read |
| mr_ctl | input | 2 | Length control for memory reads |
| mrlm_ctl | input | 1 | Length control for line/multiple reads |
| line_log2 | input | LL_W (3) | Log2 of cache line size in DWORDs |
| free_dw | input | FREE_W (7) | Free prefetch-buffer space in DWORDs |
| phase_adv | input | 1 | One outbound data phase completed |
| busy | output | 1 | A fetch is in progress |
| fetch_cnt | output | CNT_W (11) | DWORD count of the current fetch |
| remain | output | CNT_W (11) | Data phases still to run |
| phase_be | output | 4 | Byte enables for the data phases |
| disc_one | output | 1 | Disconnect initiator after one DWORD |
| last_phase | output | 1 | Current phase is the final one |

## Verification
The bench aims at the limits that cut a fetch short: a line fetch starting mid-line, a fill near the page end, a free space smaller than the line, a zero free space that must still give one DWORD, and a free space above the buffer size that must be clamped. A design that ignored the page end would overrun into the next page, one that skipped the floor would issue a zero-length fetch and hang the tracker, and one that mishandled the offset would over-fetch past the line. It also checks that byte enables pass through only on non-speculative reads, that a PCI-X DWORD read overrides a speculative command, and that a new request or a stray phase pulse cannot disturb the tracker.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;

   typedef enum logic [2:0] {
      CMD_IO_RD  = 3'd0,
      CMD_CFG_RD = 3'd1,
      CMD_MEM_RD = 3'd2,
      CMD_MEM_RL = 3'd3,
      CMD_MEM_RM = 3'd4
   } rd_cmd_e;

   typedef enum logic [1:0] {
      POL_SINGLE = 2'd0,
      POL_LINE   = 2'd1,
      POL_FILL   = 2'd2
   } fetch_pol_e;

endpackage

// File: rtl/rdpf_classify.sv
module rdpf_classify
   import rdpf_pkg::*;
(
   input  logic [2:0] cmd,
   input  logic       pf_hit,
   input  logic       pcix_mode,
   input  logic       dword_rd,
   input  logic [1:0] mr_ctl,
   input  logic       mrlm_ctl,
   output fetch_pol_e pol
);

   always_comb begin
      pol = POL_SINGLE;
      case (cmd)
         CMD_MEM_RD: begin
            if (pf_hit) begin
               case (mr_ctl)
                  2'b00:   pol = POL_SINGLE;
                  2'b01:   pol = POL_LINE;
                  default: pol = POL_FILL;
               endcase
            end
         end
         CMD_MEM_RL, CMD_MEM_RM: pol = mrlm_ctl ? POL_FILL : POL_LINE;
         default: pol = POL_SINGLE;
      endcase
      if (pcix_mode && dword_rd) pol = POL_SINGLE;
   end

endmodule

// File: rtl/rdpf_len.sv
module rdpf_len
   import rdpf_pkg::*;
#(
   parameter int BUF_DW     = 64,
   parameter int PG_W       = 10,
   parameter int LL_W       = 3,
   parameter int FREE_W     = 7,
   parameter int CNT_W      = 11,
   parameter bit PAGE_LIMIT = 1'b1
) (
   input  fetch_pol_e        pol,
   input  logic [PG_W-1:0]   dw_addr,
   input  logic [LL_W-1:0]   line_log2,
   input  logic [FREE_W-1:0] free_dw,
   output logic [CNT_W-1:0]  cnt
);

   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] BUF_CAP = CNT_W'(BUF_DW);
   localparam logic [CNT_W-1:0] PAGE_DW = CNT_W'(1) << PG_W;

   logic [CNT_W-1:0] line_sz, in_line, line_left, free_c, base, lim;

   always_comb begin
      line_sz   = ONE << line_log2;
      in_line   = CNT_W'(dw_addr) & (line_sz - ONE);
      line_left = line_sz - in_line;
      free_c    = (CNT_W'(free_dw) > BUF_CAP) ? BUF_CAP : CNT_W'(free_dw);
      case (pol)
         POL_LINE: base = (line_left < free_c) ? line_left : free_c;
         POL_FILL: base = free_c;
         default:  base = ONE;
      endcase
   end

   generate
      if (PAGE_LIMIT) begin : g_page
         logic [CNT_W-1:0] page_left;
         always_comb begin
            page_left = PAGE_DW - CNT_W'(dw_addr);
            lim       = (base < page_left) ? base : page_left;
         end
      end else begin : g_nopage
         always_comb lim = base;
      end
   endgenerate

   assign cnt = (lim == '0) ? ONE : lim;

endmodule

// File: rtl/rdpf_track.sv
module rdpf_track #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cnt,
   input  logic             phase_adv,
   output logic             busy,
   output logic [CNT_W-1:0] remain
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         remain <= cnt;
      end else if (busy && phase_adv) begin
         remain <= remain - ONE;
         if (remain == ONE) busy <= 1'b0;
      end
   end

   a_r8_nonzero_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (remain != '0));
   a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase_adv && remain > ONE) |=> (busy && remain == $past(remain) - ONE));
   a_r8_final_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase_adv && remain == ONE) |=> !busy);
   a_r9_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !phase_adv) |=> (busy && $stable(remain)));

endmodule

// File: rtl/rd_prefetch_ctl.sv
module rd_prefetch_ctl
   import rdpf_pkg::*;
#(
   parameter int BUF_DW     = 64,
   parameter int PAGE_BYTES = 4096,
   parameter int LL_W       = 3,
   parameter bit PAGE_LIMIT = 1'b1,
   localparam int PG_W      = $clog2(PAGE_BYTES / 4),
   localparam int FREE_W    = $clog2(BUF_DW + 1),
   localparam int MAX_DW    = ((PAGE_BYTES / 4) > BUF_DW) ? (PAGE_BYTES / 4) : BUF_DW,
   localparam int CNT_W     = $clog2(MAX_DW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        cmd,
   input  logic [PG_W-1:0]   dw_addr,
   input  logic [3:0]        be_in,
   input  logic              pf_hit,
   input  logic              pcix_mode,
   input  logic              dword_rd,
   input  logic [1:0]        mr_ctl,
   input  logic              mrlm_ctl,
   input  logic [LL_W-1:0]   line_log2,
   input  logic [FREE_W-1:0] free_dw,
   input  logic              phase_adv,
   output logic              busy,
   output logic [CNT_W-1:0]  fetch_cnt,
   output logic [CNT_W-1:0]  remain,
   output logic [3:0]        phase_be,
   output logic              disc_one,
   output logic              last_phase
);

   if (BUF_DW < 1) begin : g_bad_buf
      $error("BUF_DW must be at least 1");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 8) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 8");
   end
   if ((PAGE_BYTES / 4) < (1 << ((1 << LL_W) - 1))) begin : g_bad_line
      $error("largest cache line must fit in a page");
   end

   fetch_pol_e       pol;
   logic [CNT_W-1:0] len_cnt;
   logic [3:0]       be_q;
   logic             accept;

   assign accept = req_valid && !busy;

   rdpf_classify u_cls (
      .cmd       (cmd),
      .pf_hit    (pf_hit),
      .pcix_mode (pcix_mode),
      .dword_rd  (dword_rd),
      .mr_ctl    (mr_ctl),
      .mrlm_ctl  (mrlm_ctl),
      .pol       (pol)
   );

   rdpf_len #(
      .BUF_DW     (BUF_DW),
      .PG_W       (PG_W),
      .LL_W       (LL_W),
      .FREE_W     (FREE_W),
      .CNT_W      (CNT_W),
      .PAGE_LIMIT (PAGE_LIMIT)
   ) u_len (
      .pol       (pol),
      .dw_addr   (dw_addr),
      .line_log2 (line_log2),
      .free_dw   (free_dw),
      .cnt       (len_cnt)
   );

   rdpf_track #(.CNT_W(CNT_W)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .cnt       (len_cnt),
      .phase_adv (phase_adv),
      .busy      (busy),
      .remain    (remain)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_cnt <= '0;
         be_q      <= '0;
         disc_one  <= 1'b0;
      end else if (accept) begin
         fetch_cnt <= len_cnt;
         be_q      <= (pol == POL_SINGLE) ? be_in : 4'hF;
         disc_one  <= (pol == POL_SINGLE);
      end
   end

   assign phase_be   = busy ? be_q : 4'h0;
   assign last_phase = busy && (remain == CNT_W'(1));

   a_r1_single_is_one: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && disc_one) |-> (fetch_cnt == CNT_W'(1)));
   a_r3_spec_all_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !disc_one) |-> (phase_be == 4'hF));
   a_r7_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (fetch_cnt >= CNT_W'(1) && fetch_cnt <= CNT_W'(BUF_DW)));
   a_r8_remain_le_count: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (remain <= fetch_cnt));
   a_r9_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(fetch_cnt));

endmodule

// File: tb/rd_prefetch_ctl_test.sv
module rd_prefetch_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  cmd = '0;
   logic [9:0]  dw_addr = '0;
   logic [3:0]  be_in = '0;
   logic        pf_hit = 1'b0, pcix_mode = 1'b0, dword_rd = 1'b0;
   logic [1:0]  mr_ctl = '0;
   logic        mrlm_ctl = 1'b0;
   logic [2:0]  line_log2 = '0;
   logic [6:0]  free_dw = '0;
   logic        phase_adv = 1'b0;
   logic        busy, disc_one, last_phase;
   logic [10:0] fetch_cnt, remain;
   logic [3:0]  phase_be;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rd_prefetch_ctl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd(cmd),
      .dw_addr(dw_addr), .be_in(be_in), .pf_hit(pf_hit), .pcix_mode(pcix_mode),
      .dword_rd(dword_rd), .mr_ctl(mr_ctl), .mrlm_ctl(mrlm_ctl),
      .line_log2(line_log2), .free_dw(free_dw), .phase_adv(phase_adv),
      .busy(busy), .fetch_cnt(fetch_cnt), .remain(remain), .phase_be(phase_be),
      .disc_one(disc_one), .last_phase(last_phase)
   );

   typedef struct packed {
      logic [2:0]  cmd;
      logic [9:0]  dwa;
      logic [3:0]  be;
      logic        pf, px, dw;
      logic [1:0]  mr;
      logic        ml;
      logic [2:0]  ll;
      logic [6:0]  fr;
      logic [10:0] cnt;
      logic        disc;
      logic [3:0]  ebe;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 10'd0,    4'b0110, 1'b0,1'b0,1'b0, 2'd0,1'b0,3'd0, 7'd64,  11'd1,  1'b1, 4'b0110}, // R1 io
      '{3'd1, 10'd5,    4'b1010, 1'b0,1'b0,1'b0, 2'd0,1'b0,3'd0, 7'd64,  11'd1,  1'b1, 4'b1010}, // R1 cfg
      '{3'd2, 10'd3,    4'b0011, 1'b0,1'b0,1'b0, 2'd1,1'b0,3'd3, 7'd64,  11'd1,  1'b1, 4'b0011}, // R1 mrd np
      '{3'd2, 10'd8,    4'b0101, 1'b1,1'b0,1'b0, 2'd0,1'b0,3'd3, 7'd64,  11'd1,  1'b1, 4'b0101}, // R4 00
      '{3'd2, 10'd1,    4'b0010, 1'b1,1'b0,1'b0, 2'd1,1'b0,3'd3, 7'd64,  11'd7,  1'b0, 4'b1111}, // R4 R6 line
      '{3'd2, 10'd0,    4'b0001, 1'b1,1'b0,1'b0, 2'd2,1'b0,3'd0, 7'd40,  11'd40, 1'b0, 4'b1111}, // R4 fill
      '{3'd3, 10'd0,    4'b1000, 1'b0,1'b0,1'b0, 2'd0,1'b0,3'd4, 7'd64,  11'd16, 1'b0, 4'b1111}, // R5 line
      '{3'd4, 10'd1020, 4'b0000, 1'b0,1'b0,1'b0, 2'd0,1'b1,3'd0, 7'd64,  11'd4,  1'b0, 4'b1111}, // R7 page
      '{3'd4, 10'd0,    4'b0000, 1'b0,1'b0,1'b0, 2'd0,1'b1,3'd0, 7'd10,  11'd10, 1'b0, 4'b1111}, // R5 fill
      '{3'd3, 10'd16,   4'b0000, 1'b0,1'b0,1'b0, 2'd0,1'b0,3'd5, 7'd5,   11'd5,  1'b0, 4'b1111}, // R7 free
      '{3'd4, 10'd0,    4'b1100, 1'b0,1'b1,1'b1, 2'd0,1'b1,3'd0, 7'd64,  11'd1,  1'b1, 4'b1100}, // R2
      '{3'd2, 10'd0,    4'b0000, 1'b1,1'b1,1'b0, 2'd3,1'b0,3'd0, 7'd20,  11'd20, 1'b0, 4'b1111}, // R4 11
      '{3'd4, 10'd0,    4'b0000, 1'b0,1'b0,1'b0, 2'd0,1'b1,3'd0, 7'd0,   11'd1,  1'b0, 4'b1111}, // R7 floor
      '{3'd3, 10'd2,    4'b0000, 1'b0,1'b0,1'b0, 2'd0,1'b0,3'd0, 7'd64,  11'd1,  1'b0, 4'b1111}, // R6 1-dw line
      '{3'd7, 10'd0,    4'b1001, 1'b1,1'b0,1'b0, 2'd2,1'b1,3'd0, 7'd64,  11'd1,  1'b1, 4'b1001}, // R1 other
      '{3'd4, 10'd0,    4'b0000, 1'b0,1'b0,1'b0, 2'd0,1'b1,3'd0, 7'd100, 11'd64, 1'b0, 4'b1111}  // R7 clamp
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      cmd = v.cmd; dw_addr = v.dwa; be_in = v.be; pf_hit = v.pf;
      pcix_mode = v.px; dword_rd = v.dw; mr_ctl = v.mr; mrlm_ctl = v.ml;
      line_log2 = v.ll; free_dw = v.fr;
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (remain != 11'(n - i)) chk("R8 remain", int'(remain), n - i);
         if (i == n - 1) chk("R8 last_phase", int'(last_phase), 1);
         phase_adv = 1'b1;
      end
      @(negedge clk);
      phase_adv = 1'b0;
      chk("R8 busy cleared", int'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy", int'(busy), 0);
      chk("R10 fetch_cnt", int'(fetch_cnt), 0);
      chk("R10 remain", int'(remain), 0);
      chk("R10 phase_be", int'(phase_be), 0);
      chk("R10 disc_one", int'(disc_one), 0);
      chk("R10 last_phase", int'(last_phase), 0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VEC[k]);
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         $display("vector %0d", k);
         chk("R8 busy set", int'(busy), 1);
         chk("R1 R4 R5 R6 R7 fetch_cnt", int'(fetch_cnt), int'(VEC[k].cnt));
         chk("R1 R2 disc_one", int'(disc_one), int'(VEC[k].disc));
         chk("R1 R3 phase_be", int'(phase_be), int'(VEC[k].ebe));
         drain(int'(VEC[k].cnt));
      end

      // R9 new request while busy is ignored
      @(negedge clk);
      drive(VEC[8]);
      req_valid = 1'b1;
      @(negedge clk);
      drive(VEC[0]);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 cnt kept while busy", int'(fetch_cnt), 10);
      chk("R9 remain kept while busy", int'(remain), 10);
      chk("R9 be kept while busy", int'(phase_be), 15);
      chk("R9 disc kept while busy", int'(disc_one), 0);
      drain(10);

      // R9 phase_adv while idle is ignored
      phase_adv = 1'b1;
      @(negedge clk);
      @(negedge clk);
      phase_adv = 1'b0;
      chk("R9 idle busy", int'(busy), 0);
      chk("R9 idle remain", int'(remain), 0);
      chk("R9 idle cnt", int'(fetch_cnt), 10);
      chk("R9 idle last_phase", int'(last_phase), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule